// File: doc/BRIEF.md
# Symbol Phase Synchronizer

This block sits at the input of a symbol-serial decoder whose system clock runs a fixed number of cycles per symbol, set by the parameter `CPS` (two or more). A free-running phase counter produces an internal strobe once per symbol period. When the block starts, that strobe has no relation to the incoming symbols. The rising edge of the `sync_i` start pulse reloads the counter. From then on the strobe falls on the last clock cycle of each incoming symbol. At every internal strobe the block samples the 8-bit input symbol. On the next cycle it presents that symbol together with a one-cycle strobe and, where it applies, a flag marking the first symbol of a code word.

Each code word starts with `sync_i` held high for exactly one symbol period. Once the counter is aligned, a word stays "in flight" for `HOLD_SYMS` internal strobes after its start pulse. A new start pulse that arrives inside that window must keep the existing symbol grid. If it does not, a sticky misalignment flag is raised. The new edge still realigns the counter. A start edge that arrives on the very cycle of an internal strobe produces a double sample. The old strobe still captures the first symbol, and the realigned strobe captures it again. Only the second capture carries the first-symbol flag.

Top module: `symbol_phase_sync`

## Requirements
- R1: While `rst_ni` is low, `strobe_o`, `first_o` and `misalign_o` are 0, `sym_o` is 0 and the phase counter is 0. With `sync_i` low, the first `strobe_o` pulse after release comes exactly `CPS` clock edges after the release.
- R2: Without a `sync_i` rising edge, `strobe_o` pulses high for one cycle every `CPS` cycles.
- R3: If the first cycle with `sync_i` high is cycle t, then `strobe_o` is high in cycle t+`CPS` and every `CPS` cycles after that.
- R4: `sym_o` holds the value of `data_i` sampled on the clock edge that ends the strobe cycle. For an aligned word this is the last edge at which `sync_i` is high. `sym_o` does not change in any cycle where `strobe_o` is low.
- R5: If the rising edge of `sync_i` falls in a cycle where the counter is at its last count, then `strobe_o` is high in both cycle t+1 and cycle t+`CPS`. Both strobes carry the first symbol, and `first_o` is 0 on the first and 1 on the second. At the ports, this cycle is the one just before a cycle in which `strobe_o` goes high.
- R6: `first_o` is high only together with `strobe_o`. It is high exactly once per `sync_i` rising edge, in cycle t+`CPS`.
- R7: A word counts as in flight from its `sync_i` rising edge until `HOLD_SYMS` further internal strobes have occurred. A rising edge outside that window never raises `misalign_o`, whatever its phase.
- R8: A `sync_i` rising edge inside the in-flight window raises `misalign_o` in the next cycle unless `strobe_o` is high in the edge cycle. `strobe_o` high there means the edge lies a whole number of symbols after the previous grid. `misalign_o` then stays high until reset and never rises without a `sync_i` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, `CPS` cycles per symbol |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Start pulse, high for one symbol period at each code word start |
| data_i | input | DW (8) | Incoming symbol, held constant for one symbol period |
| strobe_o | output | 1 | One-cycle pulse: a new symbol is on `sym_o` |
| sym_o | output | DW (8) | Captured symbol |
| first_o | output | 1 | With `strobe_o`: this symbol opens a code word |
| misalign_o | output | 1 | Sticky: a restart broke the symbol grid while a word was in flight |

## Verification
The assertions assume that `sync_i` is high for exactly `CPS` consecutive cycles. They also assume that two rising edges are always more than `CPS` cycles apart, so the window that links a start edge to its first-symbol strobe never overlaps another edge. The stimulus sends only whole words. Each word holds at least two symbols, its first symbol is the only one under `sync_i`, and idle gaps between words are whole symbol periods. The deliberately off-grid restarts come from directed phase offsets of one or two cycles, never from a shortened sync pulse.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef struct packed {
    logic strobe;   // counter at last count of the symbol period
    logic rise;     // sync rising edge this cycle
    logic aligned;  // counter at first count of the symbol period
  } sps_evt_t;

  function automatic int unsigned sps_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sps_edge_det.sv
module sps_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/sps_phase_ctr.sv
module sps_phase_ctr #(
  parameter int unsigned CPS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  output sps_pkg::sps_evt_t evt_o
);
  localparam int unsigned CW = sps_pkg::sps_bits(CPS);
  localparam logic [CW-1:0] LAST   = CW'(CPS - 1);
  localparam logic [CW-1:0] RELOAD = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  // the sync edge cycle is count 0 of the new symbol, so reload to 1
  always_comb begin
    if (rise_i)             cnt_d = RELOAD;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + RELOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    evt_o.strobe  = (cnt_q == LAST);
    evt_o.rise    = rise_i;
    evt_o.aligned = (cnt_q == '0);
  end
endmodule

// File: rtl/sps_capture.sv
module sps_capture #(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sps_pkg::sps_evt_t evt_i,
  input  logic [DW-1:0]     data_i,
  output logic              strobe_o,
  output logic [DW-1:0]     sym_o,
  output logic              first_o
);
  logic pend_q;
  logic mark;

  // a strobe in the edge cycle is the stale one of a double sample
  assign mark = evt_i.strobe & ~evt_i.rise & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      sym_o    <= '0;
      first_o  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      strobe_o <= evt_i.strobe;
      first_o  <= mark;
      if (evt_i.strobe) sym_o <= data_i;
      if (evt_i.rise)   pend_q <= 1'b1;
      else if (mark)    pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sps_flight_mon.sv
module sps_flight_mon #(
  parameter int unsigned HOLD_SYMS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sps_pkg::sps_evt_t evt_i,
  output logic              misalign_o
);
  localparam int unsigned FW = $clog2(HOLD_SYMS + 1);
  localparam logic [FW-1:0] HOLD = FW'(HOLD_SYMS);

  logic [FW-1:0] left_q;
  logic          busy;

  assign busy = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q     <= '0;
      misalign_o <= 1'b0;
    end else begin
      if (evt_i.rise)                left_q <= HOLD;
      else if (evt_i.strobe && busy) left_q <= left_q - FW'(1);
      if (evt_i.rise && busy && !evt_i.aligned) misalign_o <= 1'b1;
    end
  end
endmodule

// File: rtl/symbol_phase_sync.sv
module symbol_phase_sync #(
  parameter int unsigned CPS       = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned HOLD_SYMS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [DW-1:0] data_i,
  output logic          strobe_o,
  output logic [DW-1:0] sym_o,
  output logic          first_o,
  output logic          misalign_o
);
  logic              rise;
  sps_pkg::sps_evt_t evt;

  sps_edge_det i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  sps_phase_ctr #(.CPS(CPS)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .evt_o  (evt)
  );

  sps_capture #(.DW(DW)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .data_i   (data_i),
    .strobe_o (strobe_o),
    .sym_o    (sym_o),
    .first_o  (first_o)
  );

  sps_flight_mon #(.HOLD_SYMS(HOLD_SYMS)) i_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .misalign_o (misalign_o)
  );
endmodule

// File: rtl/symbol_phase_sync_chk.sv
module symbol_phase_sync_chk #(
  parameter int unsigned CPS = 4,
  parameter int unsigned DW  = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_i,
  input logic          strobe_o,
  input logic [DW-1:0] sym_o,
  input logic          first_o,
  input logic          misalign_o
);
  localparam int unsigned RW = $clog2(CPS + 1);
  localparam int unsigned GW = $clog2(2 * CPS + 1);

  logic          sync_d;
  logic          rise_c;
  logic [RW-1:0] since_rise;
  logic [GW-1:0] gap;

  assign rise_c = sync_i & ~sync_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d     <= 1'b0;
      since_rise <= '0;
      gap        <= '0;
    end else begin
      sync_d <= sync_i;
      if (rise_c)                      since_rise <= RW'(1);
      else if (since_rise == RW'(CPS)) since_rise <= '0;
      else if (since_rise != '0)       since_rise <= since_rise + RW'(1);
      if (strobe_o)                    gap <= GW'(1);
      else if (gap != GW'(2 * CPS))    gap <= gap + GW'(1);
    end
  end

  assert_strobe_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (gap <= GW'(2 * CPS - 2)));

  assert_realign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rise == RW'(CPS)) |-> (strobe_o && first_o));

  assert_sym_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(sym_o));

  assert_first_needs_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> strobe_o);

  assert_misalign_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> misalign_o);

  assert_misalign_needs_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_c && !misalign_o) |=> !misalign_o);

  assert_on_grid_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_c && strobe_o && !misalign_o) |=> !misalign_o);
endmodule

bind symbol_phase_sync symbol_phase_sync_chk #(.CPS(CPS), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .strobe_o   (strobe_o),
  .sym_o      (sym_o),
  .first_o    (first_o),
  .misalign_o (misalign_o)
);

// File: tb/test_symbol_phase_sync.sv
module test_symbol_phase_sync;
  localparam int CLK_P = 10;
  localparam int CPS   = 4;
  localparam int DW    = 8;
  localparam int HOLD  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b0;
  logic [DW-1:0] data = '0;
  logic          strobe_o, first_o, misalign_o;
  logic [DW-1:0] sym_o;

  int n_cmp = 0;
  int n_bad = 0;
  int stepn = 0;
  bit done  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  symbol_phase_sync #(.CPS(CPS), .DW(DW), .HOLD_SYMS(HOLD)) i_symbol_phase_sync (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_i     (sync),
    .data_i     (data),
    .strobe_o   (strobe_o),
    .sym_o      (sym_o),
    .first_o    (first_o),
    .misalign_o (misalign_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  int            m_ph, m_left;
  bit            m_sprev, m_pend, e_stb, e_first, e_mis;
  logic [DW-1:0] e_sym;

  function automatic int next_phase(input int ph, input bit rise);
    if (rise) return 1;
    return (ph == CPS - 1) ? 0 : ph + 1;
  endfunction

  function automatic int next_left(input int left, input bit rise, input bit stb);
    if (rise) return HOLD;
    return (stb && left != 0) ? left - 1 : left;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_sprev <= 0; m_pend <= 0;
      e_stb <= 0; e_first <= 0; e_mis <= 0; e_sym <= '0;
    end else begin
      bit stb, rise;
      stb  = (m_ph == CPS - 1);
      rise = sync && !m_sprev;
      m_sprev <= sync;
      e_stb   <= stb;
      if (stb) e_sym <= data;
      e_first <= stb && !rise && m_pend;
      if (rise) m_pend <= 1;
      else if (stb && m_pend) m_pend <= 0;
      if (rise && m_left != 0 && m_ph != 0) e_mis <= 1;
      m_left <= next_left(m_left, rise, stb);
      m_ph   <= next_phase(m_ph, rise);
    end
  end

  always begin
    @(posedge clk);
    #(CLK_P / 4);
    if (rst_n && !done) begin
      chk("R2/R3 strobe", 32'(strobe_o), 32'(e_stb));
      chk("R4 sym", 32'(sym_o), 32'(e_sym));
      chk("R6 first", 32'(first_o), 32'(e_first));
      chk("R8 misalign", 32'(misalign_o), 32'(e_mis));
    end
  end

  // strobe log for directed checks
  logic [DW-1:0] log_sym [8];
  bit            log_first [8];
  int            log_t [8];
  int            log_n;

  task automatic step(input bit s, input logic [DW-1:0] d);
    sync = s;
    data = d;
    @(negedge clk);
    stepn++;
    if (strobe_o && log_n < 8) begin
      log_sym[log_n]   = sym_o;
      log_first[log_n] = first_o;
      log_t[log_n]     = stepn;
      log_n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) step(1'b0, DW'($urandom));
  endtask

  task automatic wait_phase(input int k);
    while (!strobe_o) step(1'b0, DW'($urandom));
    repeat (k) step(1'b0, DW'($urandom));
  endtask

  task automatic send_word(input int nsym, output logic [DW-1:0] v0, output int t0);
    t0 = stepn;
    log_n = 0;
    for (int s = 0; s < nsym; s++) begin
      logic [DW-1:0] v;
      v = DW'($urandom);
      if (s == 0) v0 = v;
      for (int c = 0; c < CPS; c++) step(s == 0, v);
    end
  endtask

  task automatic summary;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [DW-1:0] v0;
    int t0;
    void'($urandom(32'h5eed_1234));
    log_n = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 strobe in reset", 32'(strobe_o), 0);
    chk("R1 first in reset", 32'(first_o), 0);
    chk("R1 misalign in reset", 32'(misalign_o), 0);
    chk("R1 sym in reset", 32'(sym_o), 0);
    rst_n = 1'b1;
    t0 = stepn;
    idle(3 * CPS);
    chk("R1 first strobe after release", 32'(log_t[0] - t0), 32'(CPS));
    chk("R2 period", 32'(log_t[1] - log_t[0]), 32'(CPS));
    chk("R2 period again", 32'(log_t[2] - log_t[1]), 32'(CPS));

    // first lock at a random phase, nothing in flight
    idle($urandom % CPS);
    send_word(3, v0, t0);
    chk("R3 realign delay", 32'(log_t[0] - t0), 32'(CPS));
    chk("R4 first symbol value", 32'(log_sym[0]), 32'(v0));
    chk("R6 first flag", 32'(log_first[0]), 1);
    chk("R7 first lock no error", 32'(misalign_o), 0);

    // back-to-back on the grid, inside the window
    wait_phase(0);
    send_word(4, v0, t0);
    chk("R3 aligned restart delay", 32'(log_t[0] - t0), 32'(CPS));
    chk("R6 aligned restart flag", 32'(log_first[0]), 1);
    chk("R8 on-grid restart no error", 32'(misalign_o), 0);

    // random whole-symbol traffic
    for (int w = 0; w < 40; w++) begin
      send_word(2 + ($urandom % 5), v0, t0);
      chk("R6 random word flag", 32'(log_first[0]), 1);
      chk("R4 random word symbol", 32'(log_sym[0]), 32'(v0));
      idle(CPS * ($urandom % 3));
    end
    chk("R8 grid traffic no error", 32'(misalign_o), 0);

    // off-grid restart after the window expired
    idle((HOLD + 2) * CPS);
    wait_phase(2);
    send_word(3, v0, t0);
    chk("R7 late off-grid no error", 32'(misalign_o), 0);
    chk("R3 off-grid realign delay", 32'(log_t[0] - t0), 32'(CPS));
    chk("R4 off-grid symbol", 32'(log_sym[0]), 32'(v0));

    // double sample, outside the window
    idle((HOLD + 2) * CPS);
    wait_phase(CPS - 1);
    send_word(3, v0, t0);
    chk("R5 stale strobe time", 32'(log_t[0] - t0), 1);
    chk("R5 stale strobe symbol", 32'(log_sym[0]), 32'(v0));
    chk("R5 stale strobe unflagged", 32'(log_first[0]), 0);
    chk("R5 realigned strobe time", 32'(log_t[1] - t0), 32'(CPS));
    chk("R5 realigned strobe symbol", 32'(log_sym[1]), 32'(v0));
    chk("R5 realigned strobe flagged", 32'(log_first[1]), 1);
    chk("R7 double sample no error", 32'(misalign_o), 0);

    // off-grid restart inside the window
    send_word(2, v0, t0);
    wait_phase(1);
    chk("R8 before bad restart", 32'(misalign_o), 0);
    send_word(3, v0, t0);
    chk("R8 bad restart flagged", 32'(misalign_o), 1);
    for (int w = 0; w < 6; w++) begin
      send_word(2 + ($urandom % 3), v0, t0);
      idle(CPS * ($urandom % 2));
    end
    chk("R8 sticky", 32'(misalign_o), 1);

    // reset clears the sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears misalign", 32'(misalign_o), 0);
    chk("R1 reset clears strobe", 32'(strobe_o), 0);
    rst_n = 1'b1;
    idle(2 * CPS);
    summary();
  end
endmodule